// File: doc/BRIEF.md
# Doubleword Barrel Shifter

This block is a purely combinational 64-bit shifter for doubleword shift operations in an integer datapath. It takes a source operand and shifts it left with zero fill, right with zero fill, or right with sign fill. The shift distance comes from one of two places. The first is a 5-bit immediate field, which gives distances of 0 to 31. The second is a 64-bit register value, of which only the bottom six bits are used, giving distances of 0 to 63.

The shift is built as a logarithmic chain of six conditional stages, with distances 1, 2, 4, 8, 16 and 32. Only right-shift stages exist. A left shift reverses the bit order of the operand before the chain and reverses it again after the chain. When the immediate source is selected, the distance-32 stage cannot be enabled. The result settles within the same cycle; there is no register inside the block.

Top module: `dshift_unit`

## Requirements
- R1: With `kind_i` = 2'b00 (left), each bit i of the result equals source bit i-n for i >= n, and the n lowest result bits are zero, where n is the effective distance.
- R2: With `kind_i` = 2'b01 (logical right), result bit i equals source bit i+n for i+n < 64, and the n highest result bits are zero.
- R3: With `kind_i` = 2'b10 (arithmetic right), result bit i equals source bit i+n for i+n < 64, and the n highest result bits are copies of source bit 63.
- R4: With `use_var_i` = 0, the distance is the unsigned value of `imm_amt_i` (0 to 31), and `var_amt_i` has no effect on the result.
- R5: With `use_var_i` = 1, the distance is the unsigned value of `var_amt_i[5:0]` (0 to 63). Bits 63:6 of `var_amt_i` and all of `imm_amt_i` have no effect.
- R6: When the effective distance is zero, the result equals the source for every `kind_i` value.
- R7: The reserved code `kind_i` = 2'b11 behaves exactly like logical right (R2).
- R8: The largest distances give the exact results. With the immediate source, distance 31 is exact. With the register source, distance 63 is exact: it leaves a single bit for a left or logical right shift, and all copies of bit 63 for an arithmetic right shift.
- R9: When all inputs are zero, the result is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_i | input | 64 | Operand to be shifted |
| imm_amt_i | input | 5 | Immediate shift distance |
| var_amt_i | input | 64 | Register holding the variable distance; only bits 5:0 are used |
| kind_i | input | 2 | Shift type: 00 left, 01 logical right, 10 arithmetic right, 11 same as 01 |
| use_var_i | input | 1 | 1 selects the register distance, 0 selects the immediate |
| result_o | output | 64 | Shifted result |

## Verification
The assertions are immediate checks that are re-evaluated whenever an input changes. They assume only that every input holds a defined 0/1 value. Every code of `kind_i` and every distance is legal, so the checks cover the reserved type code and the full range of both distance sources. The stimulus sets all inputs together, and the bench reads the result only half a clock period later. The operand patterns include walking single bits, alternating bits, all ones, and values with bit 63 set and clear. The register distance is given junk in bits 63:6, so any leakage of the upper bits would show up in the result.

// File: rtl/dshift_pkg.sv
package dshift_pkg;

  typedef enum logic [1:0] {
    SK_LEFT   = 2'b00,
    SK_RLOG   = 2'b01,
    SK_RARITH = 2'b10,
    SK_RRSV   = 2'b11
  } shift_kind_e;

  // The vacated bits take the sign bit only for an arithmetic right shift.
  function automatic logic fill_value(input shift_kind_e kind, input logic msb);
    return (kind == SK_RARITH) ? msb : 1'b0;
  endfunction

  // A left shift goes through the right-shift chain with its bits reversed.
  function automatic logic needs_reverse(input shift_kind_e kind);
    return (kind == SK_LEFT);
  endfunction

endpackage

// File: rtl/dshift_amount_sel.sv
module dshift_amount_sel #(
  parameter int AW = 6,
  parameter int IW = 5,
  parameter int RW = 64
) (
  input  logic [IW-1:0] imm_i,
  input  logic [RW-1:0] reg_i,
  input  logic          use_reg_i,
  output logic [AW-1:0] amt_o
);

  logic [AW-1:0] imm_ext;
  logic [AW-1:0] reg_low;

  generate
    if (IW < AW) begin : g_pad
      assign imm_ext = {{(AW-IW){1'b0}}, imm_i};
    end else begin : g_trunc
      assign imm_ext = imm_i[AW-1:0];
    end
  endgenerate

  assign reg_low = reg_i[AW-1:0];
  assign amt_o   = use_reg_i ? reg_low : imm_ext;

  always_comb begin
    // R4
    imm_range_chk: assert (use_reg_i || (int'(amt_o) < (1 << IW)));
    // R5
    reg_low_bits_chk: assert (!use_reg_i || (amt_o == reg_i[AW-1:0]));
  end

endmodule

// File: rtl/dshift_stage.sv
module dshift_stage #(
  parameter int W    = 64,
  parameter int DIST = 1
) (
  input  logic [W-1:0] data_i,
  input  logic         en_i,
  input  logic         fill_i,
  output logic [W-1:0] data_o
);

  logic [W-1:0] moved;

  assign moved  = {{DIST{fill_i}}, data_i[W-1:DIST]};
  assign data_o = en_i ? moved : data_i;

endmodule

// File: rtl/dshift_core.sv
module dshift_core
  import dshift_pkg::*;
#(
  parameter int W  = 64,
  parameter int AW = 6
) (
  input  logic [W-1:0]  src_i,
  input  logic [AW-1:0] amt_i,
  input  shift_kind_e   kind_i,
  output logic [W-1:0]  res_o
);

  localparam int NST = AW;

  function automatic logic [W-1:0] bit_rev(input logic [W-1:0] v);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = v[W-1-i];
    return r;
  endfunction

  // Bits below position n.
  function automatic logic [W-1:0] low_mask(input logic [AW-1:0] n);
    logic [W-1:0] m;
    for (int i = 0; i < W; i++) m[i] = (i < int'(n));
    return m;
  endfunction

  // The n topmost bits.
  function automatic logic [W-1:0] high_mask(input logic [AW-1:0] n);
    logic [W-1:0] m;
    for (int i = 0; i < W; i++) m[i] = (i >= W - int'(n));
    return m;
  endfunction

  logic                    rev_en;
  logic                    fill_bit;
  logic [NST:0][W-1:0]     chain;
  logic [W-1:0]            chain_out;
  logic [W-1:0]            lmask;
  logic [W-1:0]            hmask;

  assign rev_en   = needs_reverse(kind_i);
  assign fill_bit = fill_value(kind_i, src_i[W-1]);
  assign chain[0] = rev_en ? bit_rev(src_i) : src_i;

  genvar g;
  generate
    for (g = 0; g < NST; g++) begin : g_stage
      dshift_stage #(
        .W   (W),
        .DIST(1 << g)
      ) stage_i (
        .data_i(chain[g]),
        .en_i  (amt_i[g]),
        .fill_i(fill_bit),
        .data_o(chain[g+1])
      );
    end
  endgenerate

  assign chain_out = chain[NST];
  assign res_o     = rev_en ? bit_rev(chain_out) : chain_out;

  assign lmask = low_mask(amt_i);
  assign hmask = high_mask(amt_i);

  always_comb begin
    // R1
    left_zero_fill_chk: assert (kind_i != SK_LEFT || (res_o & lmask) == '0);
    // R2
    rlog_zero_fill_chk: assert (kind_i != SK_RLOG || (res_o & hmask) == '0);
    // R7
    rrsv_zero_fill_chk: assert (kind_i != SK_RRSV || (res_o & hmask) == '0);
    // R3
    rarith_sign_fill_chk: assert (kind_i != SK_RARITH ||
                                  (res_o & hmask) == (src_i[W-1] ? hmask : '0));
    // R6
    zero_amt_identity_chk: assert (amt_i != '0 || res_o == src_i);
  end

endmodule

// File: rtl/dshift_unit.sv
module dshift_unit
  import dshift_pkg::*;
#(
  parameter int W  = 64,
  parameter int IW = 5
) (
  input  logic [W-1:0]  src_i,
  input  logic [IW-1:0] imm_amt_i,
  input  logic [W-1:0]  var_amt_i,
  input  logic [1:0]    kind_i,
  input  logic          use_var_i,
  output logic [W-1:0]  result_o
);

  localparam int AW = $clog2(W);

  logic [AW-1:0] eff_amt;
  shift_kind_e   kind;

  assign kind = shift_kind_e'(kind_i);

  dshift_amount_sel #(
    .AW(AW),
    .IW(IW),
    .RW(W)
  ) amt_sel_i (
    .imm_i    (imm_amt_i),
    .reg_i    (var_amt_i),
    .use_reg_i(use_var_i),
    .amt_o    (eff_amt)
  );

  dshift_core #(
    .W (W),
    .AW(AW)
  ) core_i (
    .src_i (src_i),
    .amt_i (eff_amt),
    .kind_i(kind),
    .res_o (result_o)
  );

  always_comb begin
    // R4
    fixed_top_stage_off_chk: assert (use_var_i || !eff_amt[AW-1]);
    // R9
    all_zero_chk: assert (src_i != '0 || result_o == '0);
  end

endmodule

// File: tb/dshift_unit_tb_top.sv
module dshift_unit_tb_top;

  typedef struct packed {
    logic [63:0] src;
    logic [4:0]  imm;
    logic [63:0] vr;
    logic [1:0]  kind;
    logic        usev;
    logic [63:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t TABLE [NV] = '{
    '{64'h1, 5'd4, 64'h0, 2'b00, 1'b0, 64'h10, 8'd1},                                           // R1
    '{64'h8000_0000_0000_0000, 5'd31, 64'h0, 2'b01, 1'b0, 64'h0000_0001_0000_0000, 8'd2},       // R2
    '{64'h8000_0000_0000_0000, 5'd0, 64'd63, 2'b10, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 8'd3},       // R3
    '{64'hF0, 5'd9, 64'hFFFF_FFFF_FFFF_FF04, 2'b00, 1'b1, 64'hF00, 8'd5},                       // R5
    '{64'h8000_0000_0000_0000, 5'd4, 64'h0, 2'b10, 1'b0, 64'hF800_0000_0000_0000, 8'd3},        // R3
    '{64'h7000_0000_0000_0000, 5'd4, 64'h0, 2'b10, 1'b0, 64'h0700_0000_0000_0000, 8'd3},        // R3
    '{64'h1234_5678_9ABC_DEF0, 5'd7, 64'h40, 2'b00, 1'b1, 64'h1234_5678_9ABC_DEF0, 8'd6},       // R6
    '{64'hFFFF_FFFF_FFFF_FFFF, 5'd0, 64'd63, 2'b00, 1'b1, 64'h8000_0000_0000_0000, 8'd8},       // R8
    '{64'h8000_0000_0000_0000, 5'd1, 64'h0, 2'b11, 1'b0, 64'h4000_0000_0000_0000, 8'd7},        // R7
    '{64'h1, 5'd31, 64'd63, 2'b00, 1'b0, 64'h8000_0000, 8'd4},                                  // R4
    '{64'hDEAD_BEEF_0000_0000, 5'd3, 64'd32, 2'b01, 1'b1, 64'h0000_0000_DEAD_BEEF, 8'd2},       // R2
    '{64'hDEAD_BEEF_0000_0000, 5'd3, 64'd32, 2'b10, 1'b1, 64'hFFFF_FFFF_DEAD_BEEF, 8'd3},       // R3
    '{64'h8000_0000_0000_0000, 5'd0, 64'hFFC0_0000_0000_003F, 2'b01, 1'b1, 64'h1, 8'd8},        // R8
    '{64'hA5A5_0000_0000_C3C3, 5'd0, 64'd17, 2'b10, 1'b0, 64'hA5A5_0000_0000_C3C3, 8'd6}        // R6
  };

  logic        clk;
  logic        rst_n;
  logic [63:0] src;
  logic [4:0]  imm;
  logic [63:0] vr;
  logic [1:0]  kind;
  logic        usev;
  logic [63:0] result;

  int n_cmp  = 0;
  int n_bad  = 0;
  bit done   = 0;

  dshift_unit dut_i (
    .src_i    (src),
    .imm_amt_i(imm),
    .var_amt_i(vr),
    .kind_i   (kind),
    .use_var_i(usev),
    .result_o (result)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Bit-by-bit model written from the requirements.
  function automatic logic [63:0] model(input logic [63:0] s, input int n, input logic [1:0] k);
    logic [63:0] r;
    for (int i = 0; i < 64; i++) begin
      if (k == 2'b00) r[i] = (i >= n) ? s[i-n] : 1'b0;
      else if (i + n < 64) r[i] = s[i+n];
      else r[i] = (k == 2'b10) ? s[63] : 1'b0;
    end
    return r;
  endfunction

  task automatic apply(input logic [63:0] s, input logic [4:0] im, input logic [63:0] v,
                       input logic [1:0] k, input logic u);
    @(posedge clk);
    src = s; imm = im; vr = v; kind = k; usev = u;
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [63:0] exp);
    n_cmp++;
    if (result !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h (src=%h imm=%0d var=%h kind=%b usev=%b)",
               req, result, exp, src, imm, vr, kind, usev);
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] pats [6];
    pats[0] = 64'h8000_0000_0000_0001;
    pats[1] = 64'hAAAA_5555_AAAA_5555;
    pats[2] = 64'hFFFF_FFFF_FFFF_FFFF;
    pats[3] = 64'h7FED_CBA9_8765_4321;
    pats[4] = 64'h0000_0000_0000_0010;
    pats[5] = 64'hC000_0000_0000_0003;

    src = '0; imm = '0; vr = '0; kind = '0; usev = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9", 64'h0);  // R9: all inputs zero

    for (int t = 0; t < NV; t++) begin
      apply(TABLE[t].src, TABLE[t].imm, TABLE[t].vr, TABLE[t].kind, TABLE[t].usev);
      check($sformatf("R%0d", TABLE[t].req), TABLE[t].exp);
    end

    // R1 R2 R3 R7: register distance, full sweep, junk in upper bits (R5)
    for (int p = 0; p < 6; p++)
      for (int k = 0; k < 4; k++)
        for (int n = 0; n < 64; n++) begin
          apply(pats[p], 5'(31 - (n % 32)), {58'h2AB_CDEF_0123_4567, 6'(n)}, 2'(k), 1'b1);
          check((k == 0) ? "R1" : (k == 2) ? "R3" : (k == 3) ? "R7" : "R2",
                model(pats[p], n, 2'(k)));
        end

    // R4: immediate distance, register value must not matter
    for (int p = 0; p < 6; p++)
      for (int k = 0; k < 4; k++)
        for (int n = 0; n < 32; n++) begin
          apply(pats[p], 5'(n), {32'hFFFF_FFFF, 26'h0, 6'(63 - n)}, 2'(k), 1'b0);
          check("R4", model(pats[p], n, 2'(k)));
        end

    // R6: zero distance from both sources, every type code
    for (int k = 0; k < 4; k++) begin
      apply(64'h9876_5432_10FE_DCBA, 5'd0, 64'hFFFF_FFFF_FFFF_FFC0, 2'(k), 1'b1);
      check("R6", 64'h9876_5432_10FE_DCBA);
      apply(64'h9876_5432_10FE_DCBA, 5'd0, 64'h3F, 2'(k), 1'b0);
      check("R6", 64'h9876_5432_10FE_DCBA);
    end

    // R8: largest immediate distance for arithmetic right
    apply(64'h8000_0000_0000_0000, 5'd31, 64'h0, 2'b10, 1'b0);
    check("R8", 64'hFFFF_FFFF_0000_0000);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule